// File: doc/BRIEF.md
# Latency-Timed Priority Bus Arbiter

This block decides which of three masters owns a shared card-side local bus: a host port and two function ports. Each master raises a request line and owns the bus while its acknowledge output is high. Software programs a priority value for each master and an 8-bit tenure length through simple write ports. A larger priority value wins, and equal values fall back to a fixed order.

When a master is granted, a tenure counter loads from the tenure register. The owner keeps the bus until that tenure has run out, unless it drops its request first. After that, a master with a strictly higher priority takes the bus away by having the owner's acknowledge withdrawn. A tenure of zero gives plain pre-emptive priority. Every withdrawal is followed by one cycle with no acknowledge before the next grant. All state, acknowledges included, changes on the falling edge of `clk_i`.

Top module: `lbarb_top`

## Requirements
- R1: While `rst_ni` is low and afterwards until a request arrives, all acknowledges are low. Reset sets all three priorities and the tenure length to zero.
- R2: If no acknowledge is high and at least one request is high, the next falling edge acknowledges the pending master with the largest priority value. Acknowledge bit 0 is the host, bit 1 is function 0 and bit 2 is function 1, and request bits use the same order.
- R3: When pending masters have equal priority, the host wins over function 0, and function 0 wins over function 1.
- R4: At most one acknowledge bit is high at any time.
- R5: After an acknowledge is withdrawn, all acknowledges stay low for exactly one cycle before the next grant. An acknowledge never moves directly from one master to another.
- R6: If the owner's request is low at a falling edge, its acknowledge is withdrawn at that edge, whatever tenure remains.
- R7: With a tenure length of 0, an owner whose request is held loses its acknowledge at the next falling edge on which another pending master has a strictly larger priority. Pending masters of equal or lower priority never pre-empt it.
- R8: With tenure length L from 1 to 255, an owner that holds its request keeps its acknowledge for at least L cycles, counting the grant edge. A strictly higher-priority pending master removes it at the L-th falling edge after the grant. The tenure length is loaded again on every new grant.
- R9: A write with `prio_wr_i` high stores `prio_data_i` as the priority of the master picked by `prio_sel_i` (0 host, 1 function 0, 2 function 1). A select value of 3 changes nothing. A write with `lat_wr_i` high stores `lat_data_i` as the tenure length.
- R10: Acknowledges change only at falling edges of `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Arbitration clock; state updates on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 3 | Bus requests: bit 0 host, bit 1 function 0, bit 2 function 1 |
| ack_o | output | 3 | Bus acknowledges (grants), same bit order as `req_i` |
| prio_wr_i | input | 1 | Priority write strobe |
| prio_sel_i | input | 2 | Master whose priority is written (3 is ignored) |
| prio_data_i | input | 2 | Priority value to write; larger wins |
| lat_wr_i | input | 1 | Tenure length write strobe |
| lat_data_i | input | 8 | Tenure length in clocks |

## Verification
A single request shows the basic grant and release. Requests from all three masters at equal priority can only be resolved by the fixed tie order, and a spread of distinct priorities shows that the value, not the index, decides the winner. A late request from a higher-priority master with tenure 0 shows immediate pre-emption, and the same request at equal priority shows that no pre-emption happens. Tenures of 4 and 255 fix the exact edge of withdrawal, and a write to select 3 shows through the outcome of a later all-request contest.

// File: rtl/lbarb_pkg.sv
package lbarb_pkg;
  localparam int N_REQ = 3;
  localparam int IDX_W = 2;

  typedef enum logic [IDX_W-1:0] {
    REQ_HOST = 2'd0,
    REQ_FN0  = 2'd1,
    REQ_FN1  = 2'd2
  } req_id_e;
endpackage

// File: rtl/lbarb_cfg.sv
module lbarb_cfg
  import lbarb_pkg::*;
#(
  parameter int PRIO_W = 2,
  parameter int LAT_W  = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           prio_wr_i,
  input  logic [IDX_W-1:0]               prio_sel_i,
  input  logic [PRIO_W-1:0]              prio_data_i,
  input  logic                           lat_wr_i,
  input  logic [LAT_W-1:0]               lat_data_i,
  output logic [N_REQ-1:0][PRIO_W-1:0]   prio_o,
  output logic [LAT_W-1:0]               lat_o
);
  logic [N_REQ-1:0][PRIO_W-1:0] prio_q;
  logic [LAT_W-1:0]             lat_q;

  for (genvar i = 0; i < N_REQ; i++) begin : g_prio
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     prio_q[i] <= '0;
      else if (prio_wr_i && prio_sel_i == IDX_W'(i))   prio_q[i] <= prio_data_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lat_q <= '0;
    else if (lat_wr_i) lat_q <= lat_data_i;
  end

  assign prio_o = prio_q;
  assign lat_o  = lat_q;

  // R9: unmapped select leaves every priority untouched
  a_r9_unmapped_sel: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (prio_wr_i && prio_sel_i >= IDX_W'(N_REQ)) |=> (prio_o == $past(prio_o)));
endmodule

// File: rtl/lbarb_pick.sv
module lbarb_pick
  import lbarb_pkg::*;
#(
  parameter int PRIO_W = 2
) (
  input  logic [N_REQ-1:0]             req_i,
  input  logic [N_REQ-1:0][PRIO_W-1:0] prio_i,
  output logic                         win_vld_o,
  output logic [IDX_W-1:0]             win_idx_o,
  output logic [N_REQ-1:0]             outranked_o
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lower index on ties
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    best      = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_i[i] && (!win_vld_o || prio_i[i] > best)) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
        best      = prio_i[i];
      end
    end
  end

  for (genvar i = 0; i < N_REQ; i++) begin : g_outr
    always_comb begin
      outranked_o[i] = 1'b0;
      for (int j = 0; j < N_REQ; j++) begin
        if (j != i && req_i[j] && prio_i[j] > prio_i[i]) outranked_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lbarb_tenure.sv
module lbarb_tenure #(
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             expired_o
);
  logic [LAT_W-1:0] cnt_q;

  // load L-1 so the tenure spans L edges including the grant edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= (lat_i == '0) ? '0 : lat_i - LAT_W'(1);
    else if (cnt_q != '0)       cnt_q <= cnt_q - LAT_W'(1);
  end

  assign expired_o = (cnt_q == '0);

  // R8: once expired, stays expired until the next grant
  a_r8_expired_sticky: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (expired_o && !load_i) |=> expired_o);
endmodule

// File: rtl/lbarb_top.sv
module lbarb_top
  import lbarb_pkg::*;
#(
  parameter int PRIO_W = 2,
  parameter int LAT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        req_i,
  output logic [2:0]        ack_o,
  input  logic              prio_wr_i,
  input  logic [1:0]        prio_sel_i,
  input  logic [PRIO_W-1:0] prio_data_i,
  input  logic              lat_wr_i,
  input  logic [LAT_W-1:0]  lat_data_i
);
  logic [N_REQ-1:0][PRIO_W-1:0] prio;
  logic [LAT_W-1:0]             lat;
  logic                         win_vld;
  logic [IDX_W-1:0]             win_idx;
  logic [N_REQ-1:0]             outr;
  logic                         tenure_done;
  logic [N_REQ-1:0]             ack_q;
  logic                         owner_vld, owner_req, owner_beaten, grant_load;

  lbarb_cfg #(.PRIO_W(PRIO_W), .LAT_W(LAT_W)) u_cfg (
    .clk_i, .rst_ni,
    .prio_wr_i, .prio_sel_i, .prio_data_i,
    .lat_wr_i, .lat_data_i,
    .prio_o (prio),
    .lat_o  (lat)
  );

  lbarb_pick #(.PRIO_W(PRIO_W)) u_pick (
    .req_i       (req_i),
    .prio_i      (prio),
    .win_vld_o   (win_vld),
    .win_idx_o   (win_idx),
    .outranked_o (outr)
  );

  lbarb_tenure #(.LAT_W(LAT_W)) u_tenure (
    .clk_i, .rst_ni,
    .load_i    (grant_load),
    .lat_i     (lat),
    .expired_o (tenure_done)
  );

  assign owner_vld    = |ack_q;
  assign owner_req    = |(ack_q & req_i);
  assign owner_beaten = |(ack_q & outr);
  assign grant_load   = !owner_vld && win_vld;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= '0;
    end else if (owner_vld) begin
      if (!owner_req || (tenure_done && owner_beaten)) ack_q <= '0;
    end else if (win_vld) begin
      ack_q <= N_REQ'(1) << win_idx;
    end
  end

  assign ack_o = ack_q;

  a_r4_one_ack: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));

  a_r5_no_handover: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (ack_o != '0) |=> (ack_o == '0 || ack_o == $past(ack_o)));

  a_r2_grant_when_idle: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (ack_o == '0 && req_i != '0) |=> (ack_o != '0));

  a_r6_drop_release: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (ack_o != '0 && (ack_o & req_i) == '0) |=> (ack_o == '0));

  a_r8_tenure_hold: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (ack_o != '0 && (ack_o & req_i) != '0 && !tenure_done) |=> $stable(ack_o));

  a_r7_unbeaten_hold: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (ack_o != '0 && (ack_o & req_i) != '0 && (ack_o & outr) == '0) |=> $stable(ack_o));
endmodule

// File: tb/tb_lbarb_top.sv
module tb_lbarb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = '0;
  logic [2:0] ack;
  logic       prio_wr = 1'b0;
  logic [1:0] prio_sel = '0;
  logic [1:0] prio_data = '0;
  logic       lat_wr = 1'b0;
  logic [7:0] lat_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lbarb_top dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ack_o(ack),
    .prio_wr_i(prio_wr), .prio_sel_i(prio_sel), .prio_data_i(prio_data),
    .lat_wr_i(lat_wr), .lat_data_i(lat_data)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ack actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one falling edge, then sample; R4 checked on every step
  task automatic tick();
    @(negedge clk);
    #1;
    n_chk++;
    if ($countones(ack) > 1) begin
      n_bad++;
      $display("FAIL R4: ack actual=%b expected=at most one bit", ack);
    end
  endtask

  task automatic set_prio(input logic [1:0] sel, input logic [1:0] val);
    prio_sel = sel; prio_data = val; prio_wr = 1'b1;
    tick();
    prio_wr = 1'b0;
  endtask

  task automatic set_lat(input logic [7:0] val);
    lat_data = val; lat_wr = 1'b1;
    tick();
    lat_wr = 1'b0;
  endtask

  task automatic go_idle();
    req = '0;
    tick(); tick();
    chk("R6 idle", ack, 3'b000);
  endtask

  task automatic t_reset();
    chk("R1 in reset", ack, 3'b000);
    rst_n = 1'b1;
    tick(); tick();
    chk("R1 after reset", ack, 3'b000);
    // reset priorities all zero -> tie order decides
    req = 3'b111;
    tick();
    chk("R1 R3 zero prios", ack, 3'b001);
    go_idle();
  endtask

  task automatic t_single();
    req = 3'b100;
    tick();
    chk("R2 single grant", ack, 3'b100);
    @(posedge clk); #1;
    chk("R10 stable over rising edge", ack, 3'b100);
    req = 3'b000;
    tick();
    chk("R6 release on drop", ack, 3'b000);
  endtask

  task automatic t_tie();
    req = 3'b110;
    tick();
    chk("R3 fn0 over fn1", ack, 3'b010);
    req = 3'b100;
    tick();
    chk("R5 withdraw", ack, 3'b000);
    tick();
    chk("R5 grant after gap", ack, 3'b100);
    go_idle();
  endtask

  task automatic t_prio();
    set_prio(2'd0, 2'd1);
    set_prio(2'd1, 2'd2);
    set_prio(2'd2, 2'd3);
    req = 3'b111;
    tick();
    chk("R2 R9 highest value wins", ack, 3'b100);
    go_idle();
  endtask

  task automatic t_preempt();
    set_prio(2'd0, 2'd3);
    set_prio(2'd1, 2'd1);
    req = 3'b010;
    tick();
    chk("R7 fn0 owns", ack, 3'b010);
    req = 3'b011;
    tick();
    chk("R7 preempt at once", ack, 3'b000);
    tick();
    chk("R5 R7 host after gap", ack, 3'b001);
    go_idle();
    set_prio(2'd0, 2'd2);
    set_prio(2'd1, 2'd2);
    set_prio(2'd2, 2'd2);
    req = 3'b100;
    tick();
    chk("R7 fn1 owns", ack, 3'b100);
    req = 3'b111;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R7 equal no preempt", ack, 3'b100);
    end
    req = 3'b011;
    tick();
    chk("R6 fn1 drop", ack, 3'b000);
    tick();
    chk("R3 host first", ack, 3'b001);
    go_idle();
  endtask

  task automatic t_tenure4();
    set_lat(8'd4);
    set_prio(2'd0, 2'd3);
    set_prio(2'd1, 2'd1);
    req = 3'b010;
    tick();
    chk("R8 fn0 owns", ack, 3'b010);
    req = 3'b011;
    for (int k = 1; k < 4; k++) begin
      tick();
      chk("R8 held in tenure", ack, 3'b010);
    end
    tick();
    chk("R8 preempt at edge 4", ack, 3'b000);
    tick();
    chk("R8 host granted", ack, 3'b001);
    go_idle();
    // early drop inside a tenure
    req = 3'b100;
    tick();
    chk("R8 fn1 owns", ack, 3'b100);
    req = 3'b000;
    tick();
    chk("R6 drop inside tenure", ack, 3'b000);
  endtask

  task automatic t_tenure255();
    set_lat(8'd255);
    req = 3'b010;
    tick();
    chk("R8 fn0 owns long", ack, 3'b010);
    req = 3'b011;
    for (int k = 1; k < 255; k++) tick();
    chk("R8 held at edge 254", ack, 3'b010);
    tick();
    chk("R8 preempt at edge 255", ack, 3'b000);
    tick();
    chk("R8 host after long", ack, 3'b001);
    go_idle();
    set_lat(8'd0);
  endtask

  task automatic t_sel3();
    set_prio(2'd0, 2'd0);
    set_prio(2'd1, 2'd0);
    set_prio(2'd2, 2'd0);
    set_prio(2'd3, 2'd3);
    req = 3'b111;
    tick();
    chk("R9 select 3 ignored", ack, 3'b001);
    go_idle();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    t_single();
    t_tie();
    t_prio();
    t_preempt();
    t_tenure4();
    t_tenure255();
    t_sel3();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule